// File: doc/BRIEF.md
# Transmit Jabber Watchdog

This block guards a transmit path against a station that never stops talking. It watches a single flag that is high while the transmit squelch sees live data. A transmission that runs longer than a set limit locks the transmitter out. While locked out, the block asks for the collision signal, lights an active-low status lamp and raises a state flag. Neighbouring logic uses that flag to hold off the signal-quality test.

Release takes two steps. The overlong transmission has to end. Then the line has to stay quiet for a long, unbroken interval. Any burst of activity during that interval starts the count again. The line idle tone is produced elsewhere. The block only asserts a request that the tone keep running whenever no data is being sent, and that request includes the whole lockout. A mode input turns jabber detection off altogether. Both timer lengths are parameters counted in clock cycles, so the same RTL fits any clock rate.

Top module: `jabber_guard`

## Requirements
- R1: After reset the block is in the normal state: `tx_data_en`=1, `col_req`=0, `jab_led_n`=1, `jab_state`=0.
- R2: When `tx_active` is high for LIMIT_CYC consecutive sampled cycles and `jab_disable` is low, the block enters jabber on the edge that samples the LIMIT_CYC-th active cycle. A run of LIMIT_CYC-1 active cycles does not cause jabber.
- R3: Any cycle with `tx_active` low clears the transmission-length count, so separate runs never add up.
- R4: In the jabber state `tx_data_en`=0, `col_req`=1, `jab_led_n`=0 and `jab_state`=1, and these hold for as long as `tx_active` stays high.
- R5: Jabber is left after UNJAB_CYC consecutive sampled cycles with `tx_active` low. After UNJAB_CYC-1 such cycles the block is still in jabber.
- R6: A cycle with `tx_active` high during the unjab interval restarts the idle count from zero.
- R7: While `jab_disable` is high in the normal state, no transmission length causes jabber, and the length count restarts from zero once `jab_disable` goes low.
- R8: `jab_disable` high in the jabber state returns the block to normal on the next edge, whatever `tx_active` is.
- R9: `idle_sig_en` is 1 whenever `tx_active` is low or the block is in jabber, and 0 only while data is being sent in the normal state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_active | input | 1 | Transmit squelch open (data present) |
| jab_disable | input | 1 | 1 turns jabber detection off |
| tx_data_en | output | 1 | 1 lets data reach the optical driver |
| col_req | output | 1 | Collision signalling request |
| jab_led_n | output | 1 | Active-low jabber lamp |
| jab_state | output | 1 | Jabber state flag for test suppression |
| idle_sig_en | output | 1 | Idle tone must be running |

## Verification
The bench hits both timer limits exactly at N-1 and at N. A design that is off by one either locks out a legal frame or releases one cycle early. It splits a long transmission with a single idle cycle, which catches a length counter that fails to clear and so adds runs together. It injects one active cycle just before the unjab count would finish, which exposes an idle timer that pauses instead of restarting. It also toggles the disable control both in the normal state and in jabber, which catches a design that ignores the control during lockout or resumes counting from a stale length.

// File: rtl/jabber_guard_pkg.sv
package jabber_guard_pkg;

  typedef enum logic {
    JG_NORMAL = 1'b0,
    JG_JABBED = 1'b1
  } jg_state_t;

  // Width needed to hold values 0 .. lim-1
  function automatic int jg_width(input int lim);
    return (lim < 2) ? 1 : $clog2(lim);
  endfunction

  // True when the count is the last one before the limit
  function automatic logic jg_at_last(input logic [31:0] cnt, input int lim);
    return cnt == 32'(lim - 1);
  endfunction

endpackage

// File: rtl/jabber_run_counter.sv
module jabber_run_counter #(
  parameter int LIM = 16,
  localparam int CW = jabber_guard_pkg::jg_width(LIM)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt,
  output logic          hit
);
  import jabber_guard_pkg::*;

  logic at_last;

  assign at_last = jg_at_last(32'(cnt), LIM);
  assign hit     = inc && !clr && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr || hit) cnt <= '0;
    else if (inc)        cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/jabber_ctrl.sv
module jabber_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic len_hit,
  input  logic idle_hit,
  input  logic jab_disable,
  output jabber_guard_pkg::jg_state_t state
);
  import jabber_guard_pkg::*;

  jg_state_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      JG_NORMAL: if (len_hit && !jab_disable) nxt = JG_JABBED;
      JG_JABBED: if (jab_disable || idle_hit) nxt = JG_NORMAL;
      default:   nxt = JG_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= JG_NORMAL;
    else        state <= nxt;
  end
endmodule

// File: rtl/jabber_guard.sv
module jabber_guard #(
  parameter int LIMIT_CYC = 1_500_000,
  parameter int UNJAB_CYC = 25_000_000,
  localparam int LW = jabber_guard_pkg::jg_width(LIMIT_CYC),
  localparam int IW = jabber_guard_pkg::jg_width(UNJAB_CYC)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_active,
  input  logic jab_disable,
  output logic tx_data_en,
  output logic col_req,
  output logic jab_led_n,
  output logic jab_state,
  output logic idle_sig_en
);
  import jabber_guard_pkg::*;

  jg_state_t       state;
  logic            in_jab;
  logic [LW-1:0]   len_cnt;
  logic [IW-1:0]   idle_cnt;
  logic            len_hit;
  logic            idle_hit;
  logic            len_clr;
  logic            idle_clr;

  assign in_jab   = (state == JG_JABBED);
  assign len_clr  = in_jab || jab_disable || !tx_active;
  assign idle_clr = !in_jab || jab_disable || tx_active;

  jabber_run_counter #(.LIM(LIMIT_CYC)) u_len (
    .clk(clk), .rst_n(rst_n), .clr(len_clr), .inc(tx_active),
    .cnt(len_cnt), .hit(len_hit)
  );

  jabber_run_counter #(.LIM(UNJAB_CYC)) u_idle (
    .clk(clk), .rst_n(rst_n), .clr(idle_clr), .inc(!tx_active),
    .cnt(idle_cnt), .hit(idle_hit)
  );

  jabber_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .len_hit(len_hit), .idle_hit(idle_hit),
    .jab_disable(jab_disable), .state(state)
  );

  assign jab_state   = in_jab;
  assign tx_data_en  = !in_jab;
  assign col_req     = in_jab;
  assign jab_led_n   = !in_jab;
  assign idle_sig_en = in_jab || !tx_active;
endmodule

// File: rtl/jabber_guard_chk.sv
module jabber_guard_chk #(
  parameter int LIMIT_CYC = 16,
  parameter int UNJAB_CYC = 16,
  localparam int LW = jabber_guard_pkg::jg_width(LIMIT_CYC),
  localparam int IW = jabber_guard_pkg::jg_width(UNJAB_CYC)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_active,
  input logic          jab_disable,
  input logic          tx_data_en,
  input logic          col_req,
  input logic          jab_led_n,
  input logic          jab_state,
  input logic          idle_sig_en,
  input logic [LW-1:0] len_cnt,
  input logic [IW-1:0] idle_cnt
);
  p_enter_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(jab_state) |-> $past(tx_active) && !$past(jab_disable));

  p_len_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    32'(len_cnt) < 32'(LIMIT_CYC));

  p_len_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_active |=> len_cnt == '0);

  p_jab_outputs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    jab_state |-> !tx_data_en && col_req && !jab_led_n);

  p_leave_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(jab_state) |-> $past(jab_disable) || !$past(tx_active));

  p_idle_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    jab_state && tx_active |=> idle_cnt == '0);

  p_disable_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !jab_state && jab_disable |=> !jab_state);

  p_disable_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    jab_state && jab_disable |=> !jab_state);

  p_idle_tone_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_active || jab_state) |-> idle_sig_en);
endmodule

bind jabber_guard jabber_guard_chk #(.LIMIT_CYC(LIMIT_CYC), .UNJAB_CYC(UNJAB_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_active(tx_active), .jab_disable(jab_disable),
  .tx_data_en(tx_data_en), .col_req(col_req), .jab_led_n(jab_led_n),
  .jab_state(jab_state), .idle_sig_en(idle_sig_en),
  .len_cnt(len_cnt), .idle_cnt(idle_cnt)
);

// File: tb/jabber_guard_test.sv
module jabber_guard_test;
  localparam int LIM = 40;
  localparam int UNJ = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_active = 1'b0;
  logic jab_disable = 1'b0;
  logic tx_data_en, col_req, jab_led_n, jab_state, idle_sig_en;

  jabber_guard #(.LIMIT_CYC(LIM), .UNJAB_CYC(UNJ)) uut (
    .clk(clk), .rst_n(rst_n), .tx_active(tx_active), .jab_disable(jab_disable),
    .tx_data_en(tx_data_en), .col_req(col_req), .jab_led_n(jab_led_n),
    .jab_state(jab_state), .idle_sig_en(idle_sig_en)
  );

  always #10 clk = ~clk;

  typedef struct {
    logic  jab;
    logic  tx;
    string tag;
  } exp_t;

  exp_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // bench-side model state
  bit m_jab = 0;
  int run_on = 0;
  int run_off = 0;

  task automatic cmp_outputs(input logic ej, input logic etx, input string tag);
    logic [4:0] got, want;
    got  = {jab_state, col_req, tx_data_en, jab_led_n, idle_sig_en};
    want = {ej, ej, !ej, !ej, ej || !etx};
    n_cmp++;
    if (got !== want) begin
      n_bad++;
      $display("FAIL %s: {jab,col,en,led_n,idle} got %b expected %b at %0t", tag, got, want, $time);
    end
  endtask

  task automatic step(input logic tx, input logic dis, input string tag);
    exp_t e;
    @(negedge clk);
    tx_active = tx;
    jab_disable = dis;
    if (!m_jab) begin
      run_on = (dis || !tx) ? 0 : run_on + 1;
      if (run_on == LIM) begin m_jab = 1; run_on = 0; run_off = 0; end
    end else begin
      if (dis) begin m_jab = 0; run_on = 0; end
      else begin
        run_off = tx ? 0 : run_off + 1;
        if (run_off == UNJ) begin m_jab = 0; run_on = 0; end
      end
    end
    e.jab = m_jab; e.tx = tx; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic run(input int n, input logic tx, input logic dis, input string tag);
    for (int i = 0; i < n; i++) step(tx, dis, tag);
  endtask

  // monitor: compares outputs after each edge against queued expectation
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      cmp_outputs(e.jab, e.tx, e.tag);
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #35;
    cmp_outputs(1'b0, 1'b0, "R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    run(5, 0, 0, "R1 idle after reset");
    // R2: one short of the limit, then idle
    run(LIM - 1, 1, 0, "R2 limit-1 active");
    run(3, 0, 0, "R2 no jab after limit-1");
    // R3: runs split by a single idle cycle do not accumulate
    run(20, 1, 0, "R3 first run");
    run(1, 0, 0, "R3 gap");
    run(LIM - 1, 1, 0, "R3 second run");
    run(2, 0, 0, "R3 no jab");
    // R2/R4: overlong transmission
    run(LIM, 1, 0, "R2 reach limit");
    run(30, 1, 0, "R4 jab held while active");
    // R6: activity just before unjab completes
    run(UNJ - 1, 0, 0, "R6 idle limit-1");
    run(1, 1, 0, "R6 burst in unjab");
    // R5: exact unjab boundary
    run(UNJ - 1, 0, 0, "R5 still jabbed at unjab-1");
    run(1, 0, 0, "R5 release at unjab");
    run(3, 0, 0, "R5 normal after release");
    // R7: disable blocks detection, count restarts when released
    run(2 * LIM, 1, 1, "R7 disabled long tx");
    run(LIM - 1, 1, 0, "R7 count from zero");
    run(1, 1, 0, "R7 jab after fresh limit");
    // R8: disable during jabber while still active
    run(5, 1, 0, "R4 jabbed");
    run(1, 1, 1, "R8 disable exits jab");
    run(3, 1, 1, "R8 stays normal");
    run(4, 0, 0, "R9 idle normal");
    run(3, 1, 0, "R9 sending normal");
    run(3, 0, 0, "R9 idle again");
    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule